// File: doc/BRIEF.md
# Six-Channel Line Capture and Serializer

This block collects one video-style line from six byte-wide sources that run in parallel. Two slow strobes pace it, both in the system clock domain. The sample strobe marks each sample slot. The line strobe is high for the active part of a line and low for the blanking gap that follows. While the line strobe is high, every rising edge of the sample strobe stores one byte from each source into that source's own 256-entry buffer. The sources change their data on the falling edge of the sample strobe, so the data is stable when it is taken.

When the line strobe falls, the block plays the six buffers out back to back on a single byte-wide stream, one byte per system clock, with a valid flag. The stream carries all of buffer 0, then buffers 1 to 5, for 1536 bytes. A 3-bit select output names the buffer whose byte is on the stream. It uses a sparse code that never takes the value 011. The readout takes about 1536 system cycles, which fits inside the blanking gap.

A line strobe that rises again before the readout has finished stops the readout and sets a sticky overrun flag. Capture of the new line then starts as normal.

Top module: `line_capture_serializer`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `out_valid_o`, `out_data_o`, `out_sel_o` and `overrun_o` are all 0.
- R2: A rising edge of `dval_i` seen while `lval_i` is 1 stores byte k of `ch_data_i` (bits 8k+7:8k) into buffer k at the next write entry, for all six buffers at once. A rising edge of `dval_i` seen while `lval_i` is 0 stores nothing.
- R3: A rising edge of `lval_i` returns the write entry to 0, so the first sample of each line lands in entry 0. The line-strobe edge itself writes nothing.
- R4: At most 256 samples are stored per line. Further sample edges in the same line are ignored, and entries not written in a line keep their earlier contents.
- R5: When the falling edge of `lval_i` is registered at clock edge E, `out_valid_o` is 0 after E and 1 after each of edges E+1 to E+1536, then 0 again.
- R6: The stream presents buffer 0 entries 0 to 255 in order, then buffer 1, and so on through buffer 5.
- R7: `out_sel_o` marks the buffer on the stream with codes 000, 001, 010, 100, 101 and 110 for buffers 0 to 5, and never shows 011 or 111 while valid.
- R8: A rising edge of `lval_i` during a readout drives `out_valid_o` low from the next cycle, sets `overrun_o`, and starts capture at entry 0. `overrun_o` stays set until reset.
- R9: `out_data_o` is 0 whenever `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dval_i | input | 1 | Sample strobe; a rising edge takes one sample per channel |
| lval_i | input | 1 | Line strobe; high during the active line, low during blanking |
| ch_data_i | input | 48 | Six packed source bytes, channel k at bits 8k+7:8k |
| out_data_o | output | 8 | Serialized byte stream |
| out_valid_o | output | 1 | High while a byte of the stream is present |
| out_sel_o | output | 3 | Code of the buffer feeding the stream |
| overrun_o | output | 1 | Sticky flag: a new line began before readout ended |

## Verification
A bad write address or a fill count that does not saturate does not show at once. It shows in the next readout as bytes in the wrong entries, or as stale data where the bench expects retained data. That readout begins two clocks after the line strobe falls. A wrong channel or entry counter in the readout sequencer shows on `out_data_o` and `out_sel_o` in the first cycle it goes wrong. A readout that is not stopped on a new line shows as `out_valid_o` still high one clock after the line strobe rises.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  localparam int SEL_W = 3;

  // Sparse buffer select code: bit 2 marks the upper group of three buffers,
  // bits 1:0 give the position within the group (value 3 never occurs).
  function automatic logic [SEL_W-1:0] sel_code(input int unsigned buf_idx);
    logic [SEL_W-1:0] code;
    code[2]   = (buf_idx >= 3);
    code[1:0] = 2'(buf_idx % 3);
    return code;
  endfunction

endpackage

// File: rtl/lcs_edge_detect.sv
module lcs_edge_detect #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= '0;
    else     sig_q <= sig_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign rise_o[b] = sig_i[b] & ~sig_q[b];
    assign fall_o[b] = ~sig_i[b] & sig_q[b];
  end

endmodule

// File: rtl/lcs_write_ctrl.sv
module lcs_write_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start_i,
  input  logic          sample_edge_i,
  input  logic          line_active_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW:0]   fill_o
);

  logic [AW:0] fill_q;
  logic [AW:0] base;

  // A new line restarts the fill count in the same cycle.
  assign base      = line_start_i ? '0 : fill_q;
  assign wr_en_o   = sample_edge_i && line_active_i && (base < (AW+1)'(DEPTH));
  assign wr_addr_o = base[AW-1:0];
  assign fill_o    = fill_q;

  always_ff @(posedge clk) begin
    if (rst) fill_q <= '0;
    else     fill_q <= base + {{AW{1'b0}}, wr_en_o};
  end

endmodule

// File: rtl/lcs_line_buffer.sv
module lcs_line_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o      <= mem[raddr_i];
  end

endmodule

// File: rtl/lcs_readout.sv
module lcs_readout
  import lcs_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             abort_i,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic             busy_o,
  output logic             out_valid_o,
  output logic [CW-1:0]    out_ch_o,
  output logic [SEL_W-1:0] out_sel_o
);

  logic          busy_q;
  logic [CW-1:0] ch_q;
  logic [AW-1:0] addr_q;
  logic          issue;
  logic          last_entry;
  logic          last_ch;

  assign issue      = busy_q && !abort_i;
  assign last_entry = (addr_q == AW'(DEPTH-1));
  assign last_ch    = (ch_q == CW'(NUM_CH-1));
  assign rd_en_o    = issue;
  assign rd_addr_o  = addr_q;
  assign busy_o     = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      ch_q        <= '0;
      addr_q      <= '0;
      out_valid_o <= 1'b0;
      out_ch_o    <= '0;
      out_sel_o   <= '0;
    end else begin
      // Output stage lags the read request by the buffer's read register.
      out_valid_o <= issue;
      if (issue) begin
        out_ch_o  <= ch_q;
        out_sel_o <= sel_code(int'(ch_q));
      end
      if (abort_i) begin
        busy_q <= 1'b0;
        ch_q   <= '0;
        addr_q <= '0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        ch_q   <= '0;
        addr_q <= '0;
      end else if (issue) begin
        if (last_entry) begin
          addr_q <= '0;
          if (last_ch) begin
            busy_q <= 1'b0;
            ch_q   <= '0;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end else begin
          addr_q <= addr_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/line_capture_serializer.sv
module line_capture_serializer
  import lcs_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DW     = 8,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dval_i,
  input  logic                 lval_i,
  input  logic [NUM_CH*DW-1:0] ch_data_i,
  output logic [DW-1:0]        out_data_o,
  output logic                 out_valid_o,
  output logic [SEL_W-1:0]     out_sel_o,
  output logic                 overrun_o
);

  // Named internal events
  logic [1:0]    strobes;
  logic [1:0]    strobe_rise;
  logic [1:0]    strobe_fall;
  logic          dval_rise;
  logic          dval_fall_unused;
  logic          lval_rise;
  logic          lval_fall;
  logic          cap_we;
  logic [AW-1:0] cap_addr;
  logic [AW:0]   wr_fill;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          rd_busy;
  logic          line_abort;
  logic [CW-1:0] out_ch;
  logic [DW-1:0] buf_rdata [NUM_CH];
  logic          overrun_q;

  assign strobes          = {lval_i, dval_i};
  assign dval_rise        = strobe_rise[0];
  assign dval_fall_unused = strobe_fall[0];
  assign lval_rise        = strobe_rise[1];
  assign lval_fall        = strobe_fall[1];
  assign line_abort       = lval_rise && rd_busy;

  lcs_edge_detect #(.W(2)) u_edges (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (strobes),
    .rise_o (strobe_rise),
    .fall_o (strobe_fall)
  );

  lcs_write_ctrl #(.DEPTH(DEPTH)) u_wctl (
    .clk           (clk),
    .rst           (rst),
    .line_start_i  (lval_rise),
    .sample_edge_i (dval_rise),
    .line_active_i (lval_i),
    .wr_en_o       (cap_we),
    .wr_addr_o     (cap_addr),
    .fill_o        (wr_fill)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_buf
    lcs_line_buffer #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .we_i    (cap_we),
      .waddr_i (cap_addr),
      .wdata_i (ch_data_i[c*DW +: DW]),
      .re_i    (rd_en),
      .raddr_i (rd_addr),
      .rdata_o (buf_rdata[c])
    );
  end

  lcs_readout #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .start_i     (lval_fall),
    .abort_i     (line_abort),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .busy_o      (rd_busy),
    .out_valid_o (out_valid_o),
    .out_ch_o    (out_ch),
    .out_sel_o   (out_sel_o)
  );

  always_ff @(posedge clk) begin
    if (rst) overrun_q <= 1'b0;
    else     overrun_q <= overrun_q | line_abort;
  end

  assign overrun_o  = overrun_q;
  assign out_data_o = out_valid_o ? buf_rdata[out_ch] : '0;

endmodule

// File: rtl/lcs_checker.sv
module lcs_checker #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst,
  input logic        lval_i,
  input logic        lval_rise,
  input logic        cap_we,
  input logic [AW:0] wr_fill,
  input logic        busy,
  input logic        out_valid,
  input logic [2:0]  out_sel,
  input logic        overrun
);

  // R2
  cap_only_in_line_chk: assert property (@(posedge clk) disable iff (rst)
    cap_we |-> lval_i);

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fill <= (AW+1)'(DEPTH));

  // R7
  sel_sparse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sel != 3'b011 && out_sel != 3'b111));

  // R6
  first_buf_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_sel == 3'b000));

  // R5
  valid_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(busy));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (lval_rise && busy) |=> (!out_valid && overrun));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

endmodule

bind line_capture_serializer lcs_checker #(.DEPTH(DEPTH)) u_lcs_chk (
  .clk       (clk),
  .rst       (rst),
  .lval_i    (lval_i),
  .lval_rise (lval_rise),
  .cap_we    (cap_we),
  .wr_fill   (wr_fill),
  .busy      (rd_busy),
  .out_valid (out_valid_o),
  .out_sel   (out_sel_o),
  .overrun   (overrun_o)
);

// File: tb/line_capture_serializer_bench.sv
module line_capture_serializer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dval = 1'b0;
  logic        lval = 1'b0;
  logic [47:0] ch_data = '0;
  logic [7:0]  out_data;
  logic        out_valid;
  logic [2:0]  out_sel;
  logic        overrun;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Bench model of buffer contents
  logic [7:0] exp_mem [6][256];
  int         model_fill = 0;

  always #2 clk = ~clk;

  line_capture_serializer u_line_capture_serializer (
    .clk         (clk),
    .rst         (rst),
    .dval_i      (dval),
    .lval_i      (lval),
    .ch_data_i   (ch_data),
    .out_data_o  (out_data),
    .out_valid_o (out_valid),
    .out_sel_o   (out_sel),
    .overrun_o   (overrun)
  );

  function automatic logic [7:0] pat(input int line, input int ch, input int idx);
    return 8'(line * 53 + ch * 29 + idx * 7 + 1);
  endfunction

  function automatic logic [2:0] exp_sel(input int b);
    case (b)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b010;
      3: return 3'b100;
      4: return 3'b101;
      default: return 3'b110;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // One sample slot: data changes with strobe low, taken on the rising edge.
  task automatic drive_sample(input int line, input int idx);
    dval = 1'b0;
    for (int c = 0; c < 6; c++) ch_data[c*8 +: 8] = pat(line, c, idx);
    repeat (2) @(negedge clk);
    dval = 1'b1;
    if (lval && model_fill < 256) begin
      for (int c = 0; c < 6; c++) exp_mem[c][model_fill] = pat(line, c, idx);
      model_fill++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic line_start();
    lval = 1'b1;
    dval = 1'b0;
    model_fill = 0;
    @(negedge clk);
  endtask

  task automatic readout_check(input string req);
    int bad = 0;
    int first = -1;
    int fa = 0;
    int fe = 0;
    lval = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R5", "valid one cycle after line end", int'(out_valid), 0);
    for (int k = 0; k < 1536; k++) begin
      @(negedge clk);
      if (out_valid !== 1'b1 || out_data !== exp_mem[k/256][k%256] ||
          out_sel !== exp_sel(k/256)) begin
        if (bad == 0) begin
          first = k;
          fa = int'(out_data);
          fe = int'(exp_mem[k/256][k%256]);
        end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("stream byte %0d", first), fa, fe);
    chk(out_sel === exp_sel(5), "R7", "select on last byte", int'(out_sel), int'(exp_sel(5)));
    @(negedge clk);
    chk(out_valid === 1'b0, "R5", "valid after 1536 bytes", int'(out_valid), 0);
    chk(out_data === 8'h00, "R9", "data while idle", int'(out_data), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    chk(out_data === 8'h00, "R1", "data after reset", int'(out_data), 0);
    chk(out_sel === 3'b000, "R1", "select after reset", int'(out_sel), 0);
    chk(overrun === 1'b0, "R1", "overrun after reset", int'(overrun), 0);
  endtask

  // R2 R3 R6 R7: full line then ordered readout
  task automatic t_full_line();
    for (int i = 0; i < 4; i++) drive_sample(90, i);
    line_start();
    for (int i = 0; i < 256; i++) drive_sample(1, i);
    readout_check("R6");
  endtask

  // R4: extra samples in a line are dropped
  task automatic t_overfull_line();
    line_start();
    for (int i = 0; i < 260; i++) drive_sample(2, i);
    readout_check("R4");
  endtask

  // R4 R2 R3: short line keeps old entries; blanking edges and an empty line write nothing
  task automatic t_short_and_blank();
    line_start();
    for (int i = 0; i < 10; i++) drive_sample(3, i);
    readout_check("R3");
    for (int i = 0; i < 12; i++) drive_sample(4, i);
    line_start();
    readout_check("R2");
  endtask

  // R8: a new line during readout
  task automatic t_overrun();
    line_start();
    for (int i = 0; i < 256; i++) drive_sample(5, i);
    lval = 1'b0;
    repeat (102) @(negedge clk);
    chk(out_valid === 1'b1, "R5", "valid mid readout", int'(out_valid), 1);
    line_start();
    chk(out_valid === 1'b0, "R8", "valid after early line start", int'(out_valid), 0);
    chk(overrun === 1'b1, "R8", "overrun set", int'(overrun), 1);
    for (int i = 0; i < 20; i++) drive_sample(6, i);
    readout_check("R8");
    chk(overrun === 1'b1, "R8", "overrun sticky", int'(overrun), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(overrun === 1'b0, "R1", "overrun cleared by reset", int'(overrun), 0);
  endtask

  initial begin
    t_reset();
    t_full_line();
    t_overfull_line();
    t_short_and_blank();
    t_overrun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule